// File: doc/BRIEF.md
# Eight-Channel UART FIFO Bus Port

This block is the memory-mapped front end that sits between a system bus and the transmit and receive queues of eight UART channels. It decodes each bus address into a channel number and an access window. It then moves bytes between the bus and the queue that the address names. Each channel has a byte-wide holding register that pushes or pops one byte per access. It also has a word-wide load window that pushes up to four transmit bytes in one write, and a paired unload window. Each 16-bit half of a read from the paired window carries one received byte together with its line-status byte.

A per-channel line-control register decides what the two lowest register slots reach. Bit 7 clear gives the holding register and the interrupt-enable register. Bit 7 set gives the low and high bytes of the baud divisor. The serial side of each channel, which lies outside this block, appends received bytes through a push port and drains transmit bytes through a pop port that shows the head byte of the selected channel.

Top module: `uart_fifo_port`

## Requirements
- R1: The address splits as channel = addr[12:10] (stride 0x400) and window = addr[9:8]: 0 registers, 1 transmit load, 2 paired receive, 3 unmapped. Reads of window 3 return zero and writes to it change nothing.
- R2: req_ready is always high. Every accepted read raises rsp_valid for exactly the following cycle, with rsp_rdata. Writes produce no response.
- R3: Register slot 0 (addr[7:0] = 0x00), with line-control bit 7 clear and req_be = 4'b0001, is the holding register. A write pushes req_wdata[7:0] onto the transmit queue. A read pops the receive queue and returns the data byte in rsp_rdata[7:0], with the upper bits zero. Register accesses with any other byte-enable pattern are ignored, and their reads return zero.
- R4: A write to the transmit load window pushes the byte of each enabled lane in ascending lane order. Lane 0 is req_wdata[7:0] and enters first.
- R5: Bytes that find the transmit queue full are dropped, and bytes from earlier lanes are kept. A drop sets tx_ovf for that channel, and the flag stays set until reset.
- R6: A paired read with req_be = 4'b0011 pops one entry. With req_be = 4'b1111 it pops up to two, the older entry in bits [15:0] and the newer in [31:16]. Each half is {status, data}: status bit 0 (word bit 8 or 24) is 1 for a real entry, and status bits 7:1 carry the rx_push_flags given at push time. Any other byte-enable pattern returns zero and pops nothing.
- R7: A half with no entry behind it reads as zero, with its status bit 0 clear, and nothing is popped for it. A holding-register read of an empty queue returns zero.
- R8: Line-control register at slot 3 is readable and writable. With its bit 7 set, slot 0 reaches the divisor low byte and slot 1 the divisor high byte, and no queue is touched. With bit 7 clear, slot 1 reaches the interrupt-enable register. Other slots, and register addresses with addr[7:4] nonzero, read zero and ignore writes.
- R9: rx_push appends {rx_push_flags, rx_push_data} to the receive queue of rx_push_chan, and a push onto a full queue is dropped. tx_head_data shows the head byte of tx_drain_chan. tx_drain pops that head, and tx_nonempty flags each channel holding data.
- R10: Each transmit and receive queue holds DEPTH (256) entries.
- R11: After reset all registers read zero, every queue is empty and tx_ovf is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 13 | Byte address |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rx_push | input | 1 | Serial side appends a received byte |
| rx_push_chan | input | 3 | Channel of the received byte |
| rx_push_data | input | 8 | Received byte |
| rx_push_flags | input | 7 | Line-status bits 7:1 for that byte |
| tx_drain | input | 1 | Serial side pops a transmit byte |
| tx_drain_chan | input | 3 | Channel to show and pop |
| tx_head_data | output | 8 | Head byte of tx_drain_chan's transmit queue |
| tx_nonempty | output | 8 | Per-channel transmit queue holds data |
| tx_ovf | output | 8 | Per-channel sticky transmit drop flag |

## Verification
On every cycle, the assertions check the response timing and the stickiness of the drop flags. They also check the shape of paired-window words: a filled upper half only behind a filled lower half, status bit 0 set in every nonzero half, zero for unsupported lane patterns, and zero from the unmapped window. Only the bench scenarios can show that the bytes come out in the right order and on the right channel. The same holds for the divisor switch, for exact counts at the 256-entry limit, and for the lanes that are kept when the queue fills mid-word. The bench checks these against a queue model.

// File: rtl/ufp_pkg.sv
package ufp_pkg;

    localparam int LANES = 4;
    localparam int WIN_LSB = 8;
    localparam int CH_LSB = 10;

    typedef enum logic [1:0] {
        WIN_REGS   = 2'd0,
        WIN_TXLOAD = 2'd1,
        WIN_RXPAIR = 2'd2,
        WIN_NONE   = 2'd3
    } win_e;

    localparam logic [3:0] SLOT_DATA = 4'd0;
    localparam logic [3:0] SLOT_IEN  = 4'd1;
    localparam logic [3:0] SLOT_LCTL = 4'd3;

    typedef struct packed {
        logic [6:0] flags;
        logic [7:0] data;
    } rx_ent_t;

    // One half of a paired-window word; bit 8 marks a real entry.
    function automatic logic [15:0] pair_half(input logic present, input rx_ent_t e);
        return present ? {e.flags, 1'b1, e.data} : 16'h0000;
    endfunction

    // Number of entries a paired read asks for, from its lane pattern.
    function automatic logic [1:0] pair_take(input logic [LANES-1:0] be);
        case (be)
            4'b0011: return 2'd1;
            4'b1111: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ufp_tx_fifo.sv
module ufp_tx_fifo
    import ufp_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES-1:0]       push_en,
    input  logic [LANES-1:0][7:0]  push_data,
    input  logic                   pop,
    output logic [7:0]             head,
    output logic                   nonempty,
    output logic                   dropped
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, free, taken;
    logic [LANES-1:0]         accept;
    logic [LANES-1:0][AW-1:0] waddr;
    logic          do_pop;

    // Compact enabled lanes in lane order into free slots.
    always_comb begin
        free    = CW'(DEPTH) - count;
        taken   = '0;
        dropped = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            accept[k] = 1'b0;
            waddr[k]  = wr_ptr + AW'(taken);
            if (push_en[k]) begin
                if (taken < free) begin
                    accept[k] = 1'b1;
                    taken     = taken + CW'(1);
                end else begin
                    dropped = 1'b1;
                end
            end
        end
    end

    assign do_pop   = pop && (count != '0);
    assign head     = mem[rd_ptr];
    assign nonempty = (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(taken);
            rd_ptr <= rd_ptr + AW'(do_pop);
            count  <= count + taken - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (accept[k]) mem[waddr[k]] <= push_data[k];
        end
    end

endmodule

// File: rtl/ufp_rx_fifo.sv
module ufp_rx_fifo
    import ufp_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_ent_t       push_ent,
    input  logic [1:0]    take,
    output rx_ent_t       head0,
    output rx_ent_t       head1,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    rx_ent_t       mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [1:0]    npop;
    logic          do_push;

    always_comb begin
        if (count == '0)         npop = 2'd0;
        else if (count == CW'(1)) npop = (take != 2'd0) ? 2'd1 : 2'd0;
        else                     npop = take;
    end

    assign do_push = push && (count != CW'(DEPTH));
    assign head0   = mem[rd_ptr];
    assign head1   = mem[rd_ptr + AW'(1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(do_push);
            rd_ptr <= rd_ptr + AW'(npop);
            count  <= count + CW'(do_push) - CW'(npop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
    import ufp_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 256,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = CH_LSB + CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              rx_push,
    input  logic [CH_W-1:0]   rx_push_chan,
    input  logic [7:0]        rx_push_data,
    input  logic [6:0]        rx_push_flags,
    input  logic              tx_drain,
    input  logic [CH_W-1:0]   tx_drain_chan,
    output logic [7:0]        tx_head_data,
    output logic [NCH-1:0]    tx_nonempty,
    output logic [NCH-1:0]    tx_ovf
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CH_W-1:0] chan;
    win_e            win;
    logic [3:0]      slot;
    logic            reg_ok, dlab, hold;
    logic [LANES-1:0] tx_en_bus;
    logic [1:0]      rx_take_bus;
    logic [31:0]     rd_next;

    logic [7:0] lctl [NCH];
    logic [7:0] ien  [NCH];
    logic [7:0] dlo  [NCH];
    logic [7:0] dhi  [NCH];

    logic [7:0]    tx_head_arr [NCH];
    rx_ent_t       rx_h0 [NCH];
    rx_ent_t       rx_h1 [NCH];
    logic [CW-1:0] rx_cnt [NCH];
    logic [NCH-1:0] tx_drop;

    assign req_ready = 1'b1;
    assign chan   = req_addr[ADDR_W-1:CH_LSB];
    assign win    = win_e'(req_addr[CH_LSB-1:WIN_LSB]);
    assign slot   = req_addr[3:0];
    assign reg_ok = (win == WIN_REGS) && (req_addr[7:4] == 4'd0) && (req_be == 4'b0001);
    assign dlab   = lctl[chan][7];
    assign hold   = reg_ok && (slot == SLOT_DATA) && !dlab;

    always_comb begin
        tx_en_bus   = '0;
        rx_take_bus = 2'd0;
        if (req_valid && req_write) begin
            if (win == WIN_TXLOAD) tx_en_bus = req_be;
            else if (hold)         tx_en_bus = 4'b0001;
        end
        if (req_valid && !req_write) begin
            if (win == WIN_RXPAIR) rx_take_bus = pair_take(req_be);
            else if (hold)         rx_take_bus = 2'd1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel;
        assign sel = (chan == CH_W'(c));

        ufp_tx_fifo #(.DEPTH(DEPTH)) u_tx (
            .clk       (clk),
            .rst       (rst),
            .push_en   (sel ? tx_en_bus : '0),
            .push_data (req_wdata),
            .pop       (tx_drain && (tx_drain_chan == CH_W'(c))),
            .head      (tx_head_arr[c]),
            .nonempty  (tx_nonempty[c]),
            .dropped   (tx_drop[c])
        );

        ufp_rx_fifo #(.DEPTH(DEPTH)) u_rx (
            .clk      (clk),
            .rst      (rst),
            .push     (rx_push && (rx_push_chan == CH_W'(c))),
            .push_ent ({rx_push_flags, rx_push_data}),
            .take     (sel ? rx_take_bus : 2'd0),
            .head0    (rx_h0[c]),
            .head1    (rx_h1[c]),
            .count    (rx_cnt[c])
        );
    end

    assign tx_head_data = tx_head_arr[tx_drain_chan];

    always_comb begin
        rd_next = '0;
        case (win)
            WIN_REGS: if (reg_ok) begin
                case (slot)
                    SLOT_DATA: rd_next[7:0] = dlab ? dlo[chan]
                                   : ((rx_cnt[chan] != '0) ? rx_h0[chan].data : 8'h00);
                    SLOT_IEN:  rd_next[7:0] = dlab ? dhi[chan] : ien[chan];
                    SLOT_LCTL: rd_next[7:0] = lctl[chan];
                    default:   rd_next = '0;
                endcase
            end
            WIN_RXPAIR: begin
                if (req_be == 4'b0011)
                    rd_next = {16'h0000, pair_half(rx_cnt[chan] != '0, rx_h0[chan])};
                else if (req_be == 4'b1111)
                    rd_next = {pair_half(rx_cnt[chan] > CW'(1), rx_h1[chan]),
                               pair_half(rx_cnt[chan] != '0, rx_h0[chan])};
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            tx_ovf    <= '0;
            for (int c = 0; c < NCH; c++) begin
                lctl[c] <= '0;
                ien[c]  <= '0;
                dlo[c]  <= '0;
                dhi[c]  <= '0;
            end
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata <= rd_next;
            tx_ovf <= tx_ovf | tx_drop;
            if (req_valid && req_write && reg_ok) begin
                case (slot)
                    SLOT_DATA: if (dlab) dlo[chan] <= req_wdata[7:0];
                    SLOT_IEN:  if (dlab) dhi[chan] <= req_wdata[7:0];
                               else      ien[chan] <= req_wdata[7:0];
                    SLOT_LCTL: lctl[chan] <= req_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_fifo_port_chk.sv
module uart_fifo_port_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic           req_write,
    input logic [1:0]     req_win,
    input logic [3:0]     req_be,
    input logic           rsp_valid,
    input logic [31:0]    rsp_rdata,
    input logic [NCH-1:0] tx_ovf
);
    logic [1:0] last_win;
    logic [3:0] last_be;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_win <= 2'd0;
            last_be  <= 4'd0;
        end else if (req_valid && !req_write) begin
            last_win <= req_win;
            last_be  <= req_be;
        end
    end

    assert_read_answered_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && last_win == 2'd3) |-> (rsp_rdata == 32'h0));

    assert_pair_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && last_win == 2'd2 && last_be != 4'b0011 && last_be != 4'b1111)
        |-> (rsp_rdata == 32'h0));

    assert_pair_marked_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && last_win == 2'd2)
        |-> ((rsp_rdata[8] || rsp_rdata[15:0] == 16'h0) &&
             (rsp_rdata[24] || rsp_rdata[31:16] == 16'h0)));

    assert_oldest_low_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && last_win == 2'd2 && !rsp_rdata[8]) |-> (rsp_rdata == 32'h0));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((tx_ovf & $past(tx_ovf)) == $past(tx_ovf)));

endmodule

bind uart_fifo_port uart_fifo_port_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_win   (req_addr[9:8]),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .tx_ovf    (tx_ovf)
);

// File: tb/tb_uart_fifo_port.sv
`timescale 1ns/1ps
module tb_uart_fifo_port;
    localparam int NCH = 8;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [12:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rx_push = 1'b0;
    logic [2:0]  rx_push_chan = '0;
    logic [7:0]  rx_push_data = '0;
    logic [6:0]  rx_push_flags = '0;
    logic        tx_drain = 1'b0;
    logic [2:0]  tx_drain_chan = '0;
    logic [7:0]  tx_head_data;
    logic [7:0]  tx_nonempty, tx_ovf;

    always #5 clk = ~clk;

    uart_fifo_port #(.NCH(NCH), .DEPTH(DEPTH)) dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  txq [NCH][$];
    logic [15:0] rxq [NCH][$];
    logic [7:0]  m_lctl [NCH], m_ien [NCH], m_dlo [NCH], m_dhi [NCH];
    logic [7:0]  m_ovf = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] mk_addr(input int ch, input int win, input int slot);
        return {ch[2:0], win[1:0], 4'h0, slot[3:0]};
    endfunction

    task automatic m_txpush(input int ch, input logic [7:0] b);
        if (txq[ch].size() < DEPTH) txq[ch].push_back(b);
        else m_ovf[ch] = 1'b1;
    endtask

    function automatic logic [15:0] m_rxpop(input int ch);
        if (rxq[ch].size() == 0) return 16'h0;
        return rxq[ch].pop_front();
    endfunction

    task automatic bus_wr(input int ch, input int win, input int slot,
                          input logic [3:0] be, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = mk_addr(ch, win, slot); req_be = be; req_wdata = d;
        if (win == 1) begin
            for (int k = 0; k < 4; k++) if (be[k]) m_txpush(ch, d[8*k +: 8]);
        end else if (win == 0 && be == 4'b0001) begin
            case (slot)
                0: if (m_lctl[ch][7]) m_dlo[ch] = d[7:0]; else m_txpush(ch, d[7:0]);
                1: if (m_lctl[ch][7]) m_dhi[ch] = d[7:0]; else m_ien[ch] = d[7:0];
                3: m_lctl[ch] = d[7:0];
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input int ch, input int win, input int slot,
                          input logic [3:0] be, input string req);
        logic [31:0] exp;
        logic [15:0] lo, hi;
        exp = '0;
        if (win == 0 && be == 4'b0001) begin
            case (slot)
                0: exp[7:0] = m_lctl[ch][7] ? m_dlo[ch] : m_rxpop(ch) & 16'h00ff;
                1: exp[7:0] = m_lctl[ch][7] ? m_dhi[ch] : m_ien[ch];
                3: exp[7:0] = m_lctl[ch];
                default: ;
            endcase
        end else if (win == 2 && be == 4'b0011) begin
            exp = {16'h0, m_rxpop(ch)};
        end else if (win == 2 && be == 4'b1111) begin
            lo = m_rxpop(ch);
            hi = m_rxpop(ch);
            exp = {hi, lo};
        end
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = mk_addr(ch, win, slot); req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(req, rsp_rdata, exp);
    endtask

    task automatic rxp(input int ch, input logic [7:0] d, input logic [6:0] f);
        rx_push = 1'b1; rx_push_chan = ch[2:0]; rx_push_data = d; rx_push_flags = f;
        if (rxq[ch].size() < DEPTH) rxq[ch].push_back({f, 1'b1, d});
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic drain(input int ch, input string req);
        tx_drain_chan = ch[2:0];
        #1;
        chk({req, " nonempty"}, 32'(tx_nonempty[ch]), 32'(txq[ch].size() != 0));
        if (txq[ch].size() != 0) chk({req, " head"}, 32'(tx_head_data), 32'(txq[ch].pop_front()));
        tx_drain = 1'b1;
        @(negedge clk);
        tx_drain = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_lctl[c] = '0; m_ien[c] = '0; m_dlo[c] = '0; m_dhi[c] = '0;
        end
        void'($urandom(32'h5eed_0c1a));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 tx_nonempty", 32'(tx_nonempty), 0);
        chk("R11 tx_ovf", 32'(tx_ovf), 0);
        chk("R11 rsp_valid", 32'(rsp_valid), 0);
        chk("R2 req_ready", 32'(req_ready), 1);
        bus_rd(0, 0, 3, 4'b0001, "R11 lctl");
        bus_rd(4, 2, 0, 4'b1111, "R11 rx empty");

        // R3 holding register, R9 drain
        bus_wr(2, 0, 0, 4'b0001, 32'h0000_00a5);
        drain(2, "R3 holding push");
        drain(2, "R9 empty drain");
        bus_wr(2, 0, 0, 4'b0011, 32'h0000_1234);
        chk("R3 wide write ignored", 32'(tx_nonempty[2]), 0);

        // R4 lane order
        bus_wr(5, 1, 0, 4'b1111, 32'h4433_2211);
        for (int i = 0; i < 4; i++) drain(5, "R4 lane order");
        bus_wr(5, 1, 0, 4'b1010, 32'hddcc_bbaa);
        for (int i = 0; i < 2; i++) drain(5, "R4 partial lanes");

        // R6 / R7 paired receive
        rxp(1, 8'h10, 7'h05); rxp(1, 8'h20, 7'h11); rxp(1, 8'h30, 7'h7f);
        bus_rd(1, 2, 0, 4'b0001, "R6 byte read of pair window");
        bus_rd(1, 2, 0, 4'b0011, "R6 half read");
        bus_rd(1, 2, 0, 4'b1111, "R6 full read");
        rxp(1, 8'h40, 7'h00);
        bus_rd(1, 2, 0, 4'b1111, "R7 single entry full read");
        bus_rd(1, 2, 0, 4'b0011, "R7 empty half read");
        bus_rd(1, 0, 0, 4'b0001, "R7 empty holding read");
        rxp(1, 8'h5a, 7'h22);
        bus_rd(1, 0, 0, 4'b1111, "R3 wide holding read");
        bus_rd(1, 0, 0, 4'b0001, "R3 holding read");

        // R8 divisor switch
        bus_wr(3, 0, 3, 4'b0001, 32'h80);
        bus_wr(3, 0, 0, 4'b0001, 32'h34);
        bus_wr(3, 0, 1, 4'b0001, 32'h12);
        chk("R8 no queue push", 32'(tx_nonempty[3]), 0);
        bus_rd(3, 0, 0, 4'b0001, "R8 divisor low");
        bus_rd(3, 0, 1, 4'b0001, "R8 divisor high");
        bus_wr(3, 0, 3, 4'b0001, 32'h03);
        bus_wr(3, 0, 1, 4'b0001, 32'h0f);
        bus_rd(3, 0, 1, 4'b0001, "R8 interrupt enable");
        bus_rd(3, 0, 3, 4'b0001, "R8 lctl readback");
        bus_wr(3, 0, 3, 4'b0001, 32'h83);
        bus_rd(3, 0, 0, 4'b0001, "R8 divisor kept");
        bus_rd(3, 0, 2, 4'b0001, "R8 other slot");
        bus_wr(3, 0, 3, 4'b0001, 32'h00);

        // R1 unmapped window
        bus_wr(0, 3, 0, 4'b1111, 32'hffff_ffff);
        chk("R1 unmapped write", 32'(tx_nonempty[0]), 0);
        rxp(0, 8'h77, 7'h01);
        bus_rd(0, 3, 0, 4'b1111, "R1 unmapped read");
        bus_rd(0, 1, 0, 4'b1111, "R1 load window read");
        bus_rd(0, 2, 0, 4'b0011, "R1 entry survives");

        // R5 / R10 overflow at depth
        for (int i = 0; i < 63; i++) bus_wr(6, 1, 0, 4'b1111, $urandom());
        bus_wr(6, 0, 0, 4'b0001, 32'h61);
        bus_wr(6, 0, 0, 4'b0001, 32'h62);
        chk("R10 no drop below depth", 32'(tx_ovf[6]), 0);
        bus_wr(6, 1, 0, 4'b1111, 32'hc4c3_c2c1);
        chk("R5 overflow flag", 32'(tx_ovf), 32'(m_ovf));
        for (int i = 0; i < DEPTH; i++) drain(6, "R5 kept bytes");
        drain(6, "R10 drained empty");
        chk("R5 sticky", 32'(tx_ovf[6]), 1);

        // R9 / R10 receive full
        for (int i = 0; i < DEPTH + 1; i++) rxp(7, 8'(i), 7'(i * 3));
        for (int i = 0; i < DEPTH / 2; i++) bus_rd(7, 2, 0, 4'b1111, "R9 full receive");
        bus_rd(7, 2, 0, 4'b1111, "R10 extra push dropped");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int ch, op;
            ch = int'($urandom_range(0, NCH - 1));
            op = int'($urandom_range(0, 9));
            case (op)
                0: bus_wr(ch, 0, 0, 4'b0001, $urandom());
                1: bus_wr(ch, 1, 0, 4'($urandom_range(0, 15)), $urandom());
                2: bus_wr(ch, 0, ($urandom_range(0, 1) != 0) ? 1 : 3, 4'b0001,
                          32'($urandom() & 32'h83));
                3: bus_rd(ch, 0, int'($urandom_range(0, 3)), 4'b0001, "R3 R8 random reg read");
                4: bus_rd(ch, 2, 0, ($urandom_range(0, 1) != 0) ? 4'b1111 : 4'b0011, "R6 random pair read");
                5: bus_rd(ch, 2, 0, 4'($urandom_range(0, 15)), "R6 random lanes");
                6, 7: rxp(ch, 8'($urandom()), 7'($urandom()));
                default: drain(ch, "R9 random drain");
            endcase
        end
        chk("R5 final flags", 32'(tx_ovf), 32'(m_ovf));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule